// File: doc/BRIEF.md
# ADC Trigger Chain Sequencer

This block turns one trigger into a programmed series of ADC conversion commands. Each trigger starts a chain of one to eight segments. A segment names a one-hot ADC command slot and an analog channel. When the conversion result returns, the segment can raise one of three done flags. Before the first command the chain waits out an initial delay. Between later commands it either waits out an interval delay or runs back-to-back on the previous result. Both delays count ticks of a shared clock pre-divider.

There are two lanes, one per ADC, and both run the same segment program. In async mode each lane follows its own trigger input. In sync mode trigger 0 starts both lanes together. Every returned result is kept per lane and per segment, and can be read back through an address pair. A four-bit status word collects the done flags and an overrun error. Each status bit is cleared by writing 1 to it. A synchronous soft-reset input holds the whole block in its reset state for as long as it is high.

Top module: `adc_chain_seq`

## Requirements
- R1: For a chain-length value n (0..7), one accepted trigger produces exactly n+1 commands on that lane, in segment order, each `cmd_valid` lasting one cycle. A new command is issued only after the previous result has returned.
- R2: The segment word for segment k occupies `seg_cfg[k*11 +: 11]`. Bits [2:0] are the one-hot slot (1, 2 or 4), bits [7:3] are the channel, bits [9:8] are the interrupt code and bit 10 is back-to-back. The `cmd_slot` and `cmd_chan` outputs carry bits [2:0] and [7:3] of the segment being issued.
- R3: Latency L is the number of clock edges from the edge that samples the trigger to the edge that raises `cmd_valid`. With `prediv` = 0, the first command comes with L = init_dly + 1.
- R4: For a segment with bit 10 clear, L is counted from the edge that samples the previous result. With `prediv` = 0 it equals intv_dly + 1.
- R5: For a segment with bit 10 set, `cmd_valid` rises on the same edge that samples the previous result (L = 0).
- R6: The delay tick comes once every prediv+1 cycles. For a delay D ≥ 1, L lies in [2+(D-1)(prediv+1), 1+D(prediv+1)]. For D = 0, L = 1.
- R7: On a sampled result, interrupt code 1, 2 or 3 sets status bit 0, 1 or 2 respectively. Code 0 sets none.
- R8: A trigger that arrives while its lane is busy sets status bit 3 and is dropped, and the running chain continues unchanged.
- R9: Writing 1 to a `status_clr` bit clears that status bit. When a set and a clear of the same bit fall in the same cycle, the set wins.
- R10: Result k of lane l is readable on `rd_data` when `rd_lane` = l and `rd_seg` = k.
- R11: In async mode (`sync_mode` = 0) each lane starts only on its own trigger bit. In sync mode, `trig[0]` starts every lane and the other trigger bits have no effect.
- R12: While `srst` is high there are no commands, status reads 0, every stored result reads 0, and a chain that was under way is abandoned.
- R13: After `rst_n` reset, `cmd_valid` is low, status is 0 and the results read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| srst | input | 1 | Synchronous soft reset, held |
| prediv | input | 8 | Delay tick pre-divider, tick every prediv+1 cycles |
| sync_mode | input | 1 | 1: trig[0] starts all lanes |
| chain_len | input | 3 | Segments per chain minus one |
| init_dly | input | 8 | Ticks before the first command |
| intv_dly | input | 8 | Ticks between a result and a non-back-to-back command |
| seg_cfg | input | 88 | Eight packed 11-bit segment words |
| trig | input | 2 | Per-lane trigger pulse |
| cmd_valid | output | 2 | Per-lane command strobe |
| cmd_slot | output | 6 | Per-lane one-hot command slot |
| cmd_chan | output | 10 | Per-lane channel number |
| res_valid | input | 2 | Per-lane result strobe from the ADC |
| res_data | input | 24 | Per-lane 12-bit conversion result |
| status | output | 4 | done0, done1, done2, error in bits 0..3 |
| status_clr | input | 4 | Write-1-to-clear strobes for status |
| rd_lane | input | 1 | Readback lane select |
| rd_seg | input | 3 | Readback segment select |
| rd_data | output | 12 | Stored result addressed by rd_lane/rd_seg |

## Verification
A done flag set by a returning result can fall in the same cycle as a software write-1-clear of that same status bit. The bench computes the exact cycle in which its ADC model presents the result and drives `status_clr` in that cycle. It then requires the bit to read 1 on the following cycle, and then 0 after a separate clear. A second collision is a new trigger that arrives while the lane's chain is still counting its delay. The bench judges it by the error bit and by the number of commands, which must match the original chain exactly.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  localparam int SLOT_W = 3;
  localparam int IRQ_W  = 2;

  typedef enum logic [1:0] {
    S_IDLE,
    S_WAIT,
    S_ISSUE,
    S_RESULT
  } lane_state_e;

  // number of segments for a length-minus-one field
  function automatic int unsigned seg_total(input int unsigned len_m1);
    return len_m1 + 32'd1;
  endfunction

  // interrupt code to status-bit mask: 1->bit0, 2->bit1, 3->bit2, 0->none
  function automatic logic [2:0] irq_route(input logic [IRQ_W-1:0] code);
    case (code)
      2'd1:    return 3'b001;
      2'd2:    return 3'b010;
      2'd3:    return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/adcseq_prediv.sv
module adcseq_prediv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic [DIV_W-1:0] prediv,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (srst)           cnt <= '0;
    else if (cnt >= prediv)  cnt <= '0;
    else                     cnt <= cnt + DIV_W'(1);
  end

  assign tick = !srst && (cnt >= prediv);

  // no two ticks back to back unless the divider is 1
  assert_tick_gap_R6: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (tick && prediv != '0 && $stable(prediv)) |=> !tick);

endmodule

// File: rtl/adcseq_lane.sv
module adcseq_lane import adcseq_pkg::*; #(
  parameter int MAX_SEG = 8,
  parameter int CH_W    = 5,
  parameter int RES_W   = 12,
  parameter int DLY_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     srst,
  input  logic                     tick,
  input  logic                     trig,
  input  logic [$clog2(MAX_SEG)-1:0] chain_len,
  input  logic [DLY_W-1:0]         init_dly,
  input  logic [DLY_W-1:0]         intv_dly,
  input  logic [MAX_SEG*(CH_W+SLOT_W+IRQ_W+1)-1:0] seg_cfg,
  output logic                     cmd_valid,
  output logic [SLOT_W-1:0]        cmd_slot,
  output logic [CH_W-1:0]          cmd_chan,
  input  logic                     res_valid,
  input  logic [RES_W-1:0]         res_data,
  output logic [MAX_SEG*RES_W-1:0] results,
  output logic [2:0]               done_set,
  output logic                     err_set
);
  localparam int IDX_W = $clog2(MAX_SEG);
  localparam int SEG_W = CH_W + SLOT_W + IRQ_W + 1;
  localparam int B2B_B = SEG_W - 1;
  localparam int IRQ_B = SLOT_W + CH_W;

  lane_state_e      st;
  logic [IDX_W-1:0] seg, seg_nx;
  logic [DLY_W-1:0] cnt;
  logic [SEG_W-1:0] cur, nxt;
  logic             last_seg, res_take;

  assign seg_nx   = seg + IDX_W'(1);
  assign cur      = seg_cfg[int'(seg)*SEG_W +: SEG_W];
  assign nxt      = seg_cfg[int'(seg_nx)*SEG_W +: SEG_W];
  assign last_seg = (32'(seg) + 32'd1) == seg_total(32'(chain_len));
  assign res_take = (st == S_RESULT) && res_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; seg <= '0; cnt <= '0;
    end else if (srst) begin
      st <= S_IDLE; seg <= '0; cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (trig) begin
          seg <= '0; cnt <= init_dly; st <= S_WAIT;
        end
        S_WAIT: begin
          if (cnt == '0) st <= S_ISSUE;
          else if (tick) cnt <= cnt - DLY_W'(1);
        end
        S_ISSUE: st <= S_RESULT;
        S_RESULT: if (res_valid) begin
          if (last_seg) st <= S_IDLE;
          else begin
            seg <= seg_nx;
            if (nxt[B2B_B]) st <= S_ISSUE;
            else begin cnt <= intv_dly; st <= S_WAIT; end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // one result register per segment
  for (genvar g = 0; g < MAX_SEG; g++) begin : g_res
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                results[g*RES_W +: RES_W] <= '0;
      else if (srst)                             results[g*RES_W +: RES_W] <= '0;
      else if (res_take && seg == IDX_W'(g))     results[g*RES_W +: RES_W] <= res_data;
    end
  end

  assign cmd_valid = (st == S_ISSUE);
  assign cmd_slot  = cur[SLOT_W-1:0];
  assign cmd_chan  = cur[SLOT_W +: CH_W];
  assign done_set  = res_take ? irq_route(cur[IRQ_B +: IRQ_W]) : 3'b000;
  assign err_set   = trig && (st != S_IDLE);

  assert_cmd_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n || srst)
    cmd_valid |=> !cmd_valid);

  assert_b2b_immediate_R5: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (st == S_RESULT && res_valid && !last_seg && nxt[B2B_B]) |=> cmd_valid);

  assert_busy_trig_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (trig && st == S_WAIT && cnt != '0) |=> (st == S_WAIT && seg == $past(seg) && cnt <= $past(cnt)));

endmodule

// File: rtl/adc_chain_seq.sv
module adc_chain_seq import adcseq_pkg::*; #(
  parameter int NUM_ADC = 2,
  parameter int MAX_SEG = 8,
  parameter int CH_W    = 5,
  parameter int RES_W   = 12,
  parameter int DLY_W   = 8,
  parameter int DIV_W   = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              srst,
  input  logic [DIV_W-1:0]                  prediv,
  input  logic                              sync_mode,
  input  logic [$clog2(MAX_SEG)-1:0]        chain_len,
  input  logic [DLY_W-1:0]                  init_dly,
  input  logic [DLY_W-1:0]                  intv_dly,
  input  logic [MAX_SEG*(CH_W+6)-1:0]       seg_cfg,
  input  logic [NUM_ADC-1:0]                trig,
  output logic [NUM_ADC-1:0]                cmd_valid,
  output logic [NUM_ADC*3-1:0]              cmd_slot,
  output logic [NUM_ADC*CH_W-1:0]           cmd_chan,
  input  logic [NUM_ADC-1:0]                res_valid,
  input  logic [NUM_ADC*RES_W-1:0]          res_data,
  output logic [3:0]                        status,
  input  logic [3:0]                        status_clr,
  input  logic [$clog2(NUM_ADC)-1:0]        rd_lane,
  input  logic [$clog2(MAX_SEG)-1:0]        rd_seg,
  output logic [RES_W-1:0]                  rd_data
);
  logic                     tick;
  logic [NUM_ADC-1:0]       lane_trig, lane_err;
  logic [2:0]               lane_done [NUM_ADC];
  logic [MAX_SEG*RES_W-1:0] lane_res  [NUM_ADC];
  logic [3:0]               set_any;

  adcseq_prediv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .srst(srst), .prediv(prediv), .tick(tick)
  );

  for (genvar l = 0; l < NUM_ADC; l++) begin : g_lane
    // sync mode: every lane follows trigger 0
    if (l == 0) begin : g_own
      assign lane_trig[l] = trig[0];
    end else begin : g_sel
      assign lane_trig[l] = sync_mode ? trig[0] : trig[l];
    end

    adcseq_lane #(
      .MAX_SEG(MAX_SEG), .CH_W(CH_W), .RES_W(RES_W), .DLY_W(DLY_W)
    ) u_lane (
      .clk(clk), .rst_n(rst_n), .srst(srst), .tick(tick),
      .trig(lane_trig[l]), .chain_len(chain_len),
      .init_dly(init_dly), .intv_dly(intv_dly), .seg_cfg(seg_cfg),
      .cmd_valid(cmd_valid[l]), .cmd_slot(cmd_slot[l*3 +: 3]),
      .cmd_chan(cmd_chan[l*CH_W +: CH_W]),
      .res_valid(res_valid[l]), .res_data(res_data[l*RES_W +: RES_W]),
      .results(lane_res[l]), .done_set(lane_done[l]), .err_set(lane_err[l])
    );
  end

  always_comb begin
    set_any = '0;
    for (int l = 0; l < NUM_ADC; l++) set_any = set_any | {lane_err[l], lane_done[l]};
  end

  // set has priority over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     status <= '0;
    else if (srst)  status <= '0;
    else            status <= (status & ~status_clr) | set_any;
  end

  assign rd_data = lane_res[rd_lane][int'(rd_seg)*RES_W +: RES_W];

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n || srst)
    set_any[0] |=> status[0]);

  assert_srst_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (status == '0 && cmd_valid == '0));

endmodule

// File: tb/sim_adc_chain_seq.sv
module sim_adc_chain_seq;
  localparam int NA = 2, MS = 8, CW = 5, RW = 12, DW = 8, PW = 8, SW = CW + 6, LAT = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, srst, sync_mode;
  logic [PW-1:0] prediv;
  logic [2:0] chain_len;
  logic [DW-1:0] init_dly, intv_dly;
  logic [MS*SW-1:0] seg_cfg;
  logic [NA-1:0] trig, cmd_valid;
  logic [NA-1:0] res_valid = '0;
  logic [NA*RW-1:0] res_data = '0;
  logic [NA*3-1:0] cmd_slot;
  logic [NA*CW-1:0] cmd_chan;
  logic [3:0] status, status_clr;
  logic [0:0] rd_lane;
  logic [2:0] rd_seg;
  logic [RW-1:0] rd_data;

  adc_chain_seq #(.NUM_ADC(NA), .MAX_SEG(MS), .CH_W(CW), .RES_W(RW), .DLY_W(DW), .DIV_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .srst(srst), .prediv(prediv), .sync_mode(sync_mode),
    .chain_len(chain_len), .init_dly(init_dly), .intv_dly(intv_dly), .seg_cfg(seg_cfg),
    .trig(trig), .cmd_valid(cmd_valid), .cmd_slot(cmd_slot), .cmd_chan(cmd_chan),
    .res_valid(res_valid), .res_data(res_data), .status(status), .status_clr(status_clr),
    .rd_lane(rd_lane), .rd_seg(rd_seg), .rd_data(rd_data)
  );

  typedef struct { int lane; int slot; int chan; int lmin; int lmax; } exp_t;
  exp_t exp_q[$];

  int cyc = 0, checks = 0, fails = 0;
  int ref_cyc[NA], pend[NA], cd[NA], seg_ctr[NA], cmds_seen[NA], chan_cap[NA];
  logic [RW-1:0] exp_res[NA][MS];
  bit finished = 0;

  always @(posedge clk) cyc++;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_rng(string req, string what, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  function automatic logic [SW-1:0] mkseg(bit b2b, int irq, int chan, int slot);
    return {b2b, 2'(irq), 5'(chan), 3'(slot)};
  endfunction

  // latency window from the requirements (R3, R4, R5, R6); d < 0 means back-to-back
  task automatic lat_window(int d, int p, output int lo, output int hi);
    if (d < 0)       begin lo = 0; hi = 0; end
    else if (d == 0) begin lo = 1; hi = 1; end
    else begin lo = 2 + (d - 1) * (p + 1); hi = 1 + d * (p + 1); end
  endtask

  task automatic expect_chain(logic [NA-1:0] lanes);
    for (int k = 0; k <= int'(chain_len); k++) begin
      logic [SW-1:0] s;
      int d, lo, hi;
      s = seg_cfg[k*SW +: SW];
      if (k == 0)        d = int'(init_dly);
      else if (s[SW-1])  d = -1;
      else               d = int'(intv_dly);
      lat_window(d, int'(prediv), lo, hi);
      for (int l = 0; l < NA; l++)
        if (lanes[l]) exp_q.push_back('{l, int'(s[2:0]), int'(s[3 +: CW]), lo, hi});
    end
  endtask

  task automatic fire(logic [NA-1:0] pins, logic [NA-1:0] started);
    @(negedge clk);
    trig = pins;
    for (int l = 0; l < NA; l++) if (started[l]) begin ref_cyc[l] = cyc; seg_ctr[l] = 0; end
    @(negedge clk);
    trig = '0;
  endtask

  task automatic wait_idle();
    int t;
    t = 0;
    do begin @(negedge clk); t++; end
    while ((exp_q.size() != 0 || pend[0] != 0 || pend[1] != 0) && t < 5000);
    chk("R1", "chain completion before timeout", int'(t < 5000), 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic clr_status(logic [3:0] m);
    @(negedge clk); status_clr = m;
    @(negedge clk); status_clr = '0;
  endtask

  task automatic rb(int lane, int sg, int exp, string req);
    rd_lane = 1'(lane); rd_seg = 3'(sg);
    #1;
    chk(req, $sformatf("result lane %0d seg %0d", lane, sg), int'(rd_data), exp);
  endtask

  // monitor: compares every command against the scoreboard queue
  always @(negedge clk) if (rst_n) begin
    for (int l = 0; l < NA; l++) if (cmd_valid[l]) begin
      exp_t it;
      int lat;
      lat = cyc - ref_cyc[l] - 1;
      cmds_seen[l]++;
      if (exp_q.size() == 0) chk("R1", $sformatf("unexpected command lane %0d", l), 1, 0);
      else begin
        it = exp_q.pop_front();
        chk("R11", "command lane", l, it.lane);
        chk("R2", "command slot", int'(cmd_slot[l*3 +: 3]), it.slot);
        chk("R2", "command channel", int'(cmd_chan[l*CW +: CW]), it.chan);
        chk_rng("R3/R4/R5/R6", "command latency", lat, it.lmin, it.lmax);
      end
    end
  end

  // ADC model: answers each command LAT cycles later
  always @(negedge clk) begin
    for (int l = 0; l < NA; l++) begin
      res_valid[l] = 1'b0;
      if (pend[l] != 0) begin
        if (cd[l] == 1) begin
          logic [RW-1:0] v;
          v = RW'(l * 256 + chan_cap[l] * 4 + 3);
          res_valid[l] = 1'b1;
          res_data[l*RW +: RW] = v;
          if (seg_ctr[l] < MS) exp_res[l][seg_ctr[l]] = v;
          seg_ctr[l]++;
          ref_cyc[l] = cyc;
          pend[l] = 0;
        end else cd[l]--;
      end
      if (rst_n && cmd_valid[l]) begin
        pend[l] = 1; cd[l] = LAT; chan_cap[l] = int'(cmd_chan[l*CW +: CW]);
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    int c0, base;
    for (int l = 0; l < NA; l++) begin
      ref_cyc[l] = 0; pend[l] = 0; cd[l] = 0; seg_ctr[l] = 0; cmds_seen[l] = 0; chan_cap[l] = 0;
    end
    rst_n = 0; srst = 0; sync_mode = 0; prediv = '0; chain_len = '0;
    init_dly = '0; intv_dly = '0; seg_cfg = '0; trig = '0; status_clr = '0;
    rd_lane = '0; rd_seg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R13: reset state
    chk("R13", "cmd_valid after reset", int'(cmd_valid), 0);
    chk("R13", "status after reset", int'(status), 0);
    rb(0, 0, 0, "R13");

    // T1: async lane 0, three segments, mixed spacing
    chain_len = 3'd2; init_dly = 8'd4; intv_dly = 8'd2; prediv = '0;
    seg_cfg = '0;
    seg_cfg[0*SW +: SW] = mkseg(0, 1, 5, 1);
    seg_cfg[1*SW +: SW] = mkseg(1, 0, 9, 2);
    seg_cfg[2*SW +: SW] = mkseg(0, 3, 31, 4);
    expect_chain(2'b01);
    fire(2'b01, 2'b01);
    wait_idle();
    chk("R1", "lane 0 command count", cmds_seen[0], 3);
    chk("R11", "lane 1 silent in async mode", cmds_seen[1], 0);
    chk("R7", "status after codes 1,0,3", int'(status), 4'b0101);
    for (int k = 0; k < 3; k++) rb(0, k, int'(exp_res[0][k]), "R10");

    // T2: write-1-clear of a single bit
    clr_status(4'b0001);
    chk("R9", "status after clearing bit 0", int'(status), 4'b0100);
    clr_status(4'hF);

    // T3: sync mode, shortest chain
    sync_mode = 1; chain_len = 3'd0; init_dly = '0;
    seg_cfg[0*SW +: SW] = mkseg(0, 2, 7, 2);
    base = cmds_seen[1];
    expect_chain(2'b11);
    fire(2'b01, 2'b11);
    wait_idle();
    chk("R11", "sync: lane 1 started by trig[0]", cmds_seen[1] - base, 1);
    chk("R7", "status after code 2", int'(status), 4'b0010);
    base = cmds_seen[0] + cmds_seen[1];
    fire(2'b10, 2'b00);
    repeat (30) @(negedge clk);
    chk("R11", "sync: trig[1] alone starts nothing", cmds_seen[0] + cmds_seen[1], base);
    chk("R11", "sync: trig[1] alone leaves status", int'(status), 4'b0010);
    clr_status(4'hF);

    // T4: async lane 1, full eight segments, divided tick
    sync_mode = 0; chain_len = 3'd7; init_dly = 8'd2; intv_dly = 8'd1; prediv = 8'd3;
    for (int k = 0; k < MS; k++)
      seg_cfg[k*SW +: SW] = mkseg(k % 2 == 1, k % 4, k * 3 + 1, 1 << (k % 3));
    base = cmds_seen[1];
    expect_chain(2'b10);
    fire(2'b10, 2'b10);
    wait_idle();
    chk("R1", "lane 1 eight-segment count", cmds_seen[1] - base, 8);
    chk("R7", "status after codes 0..3", int'(status), 4'b0111);
    for (int k = 0; k < MS; k++) rb(1, k, int'(exp_res[1][k]), "R10");
    clr_status(4'hF);

    // T5: trigger while busy is dropped and flagged
    prediv = '0; chain_len = 3'd1; init_dly = 8'd6;
    seg_cfg[0*SW +: SW] = mkseg(0, 0, 2, 1);
    seg_cfg[1*SW +: SW] = mkseg(1, 0, 3, 4);
    base = cmds_seen[0];
    expect_chain(2'b01);
    fire(2'b01, 2'b01);
    @(negedge clk);
    fire(2'b01, 2'b00);
    wait_idle();
    chk("R8", "commands with dropped trigger", cmds_seen[0] - base, 2);
    chk("R8", "error bit set", int'(status), 4'b1000);
    clr_status(4'hF);

    // T6: done set and write-1-clear in the same cycle
    chain_len = 3'd0; init_dly = '0;
    seg_cfg[0*SW +: SW] = mkseg(0, 1, 4, 1);
    expect_chain(2'b01);
    @(negedge clk);
    c0 = cyc;
    trig = 2'b01; ref_cyc[0] = cyc; seg_ctr[0] = 0;
    @(negedge clk);
    trig = '0;
    while (cyc != c0 + 2 + LAT) @(negedge clk);
    status_clr = 4'b0001;
    @(negedge clk);
    status_clr = '0;
    chk("R9", "set wins over same-cycle clear", int'(status[0]), 1);
    wait_idle();
    clr_status(4'b0001);
    chk("R9", "bit 0 cleared afterwards", int'(status), 0);

    // T7: soft reset abandons a chain and clears storage
    chain_len = 3'd3; init_dly = 8'd10;
    base = cmds_seen[0];
    fire(2'b01, 2'b01);
    repeat (2) @(negedge clk);
    srst = 1;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      chk("R12", "no command during soft reset", int'(cmd_valid), 0);
      chk("R12", "status zero during soft reset", int'(status), 0);
      @(negedge clk);
    end
    for (int k = 0; k < MS; k++) rb(1, k, 0, "R12");
    srst = 0;
    repeat (40) @(negedge clk);
    chk("R12", "abandoned chain issues nothing", cmds_seen[0] - base, 0);
    chk("R12", "status still zero", int'(status), 0);

    finished = 1;
    summary();
    $finish;
  end

endmodule